// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block is the status and interrupt side of an SPI master. It owns the transmit and receive byte FIFOs and their occupancy counters. It decodes a small register bank on a 32-bit register bus and drives a single interrupt line. The serial shift engine sits beside it. The engine takes the oldest transmit byte one at a time and hands received bytes back one at a time. The engine also reads the decoded global settings, which are enable, internal loopback, and the two FIFO threshold fields. It also reads the stored command word and the per-chip-select mode words.

Software fills the transmit FIFO with four-byte word writes, or with byte writes for a short tail. It drains the receive FIFO with word reads, then finishes a trailing partial word with byte reads. The event register is the place to poll. One word holds the live byte counts of both FIFOs, the two live level flags, and four sticky error flags that software clears by writing a one. The mask register picks which of these flags raise the interrupt.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset the event register reads 0x00000100, which is the transmit-not-full flag alone. The mode, mask, command and all chip-select mode registers read zero, and the interrupt is low.
- R2: The mode register keeps only four fields. Bit 31 is enable and drives cfgEnable. Bit 30 is loopback and drives cfgLoop. Bits 13:8 are the transmit threshold (cfgTxThr) and bits 5:0 are the receive threshold (cfgRxThr). Every other bit reads zero.
- R3: The command register at 0x00C holds all 32 bits and drives cfgCommand. Chip-select mode register n sits at 0x020+4n, holds all 32 bits and drives cfgCsMode[32n+31:32n].
- R4: A word write to 0x010 pushes four bytes into the transmit FIFO, bits 31:24 first. A byte write (busByte=1) pushes busWdata[7:0]. engTxByte always shows the oldest byte, and each engTxPop removes that byte.
- R5: A word read of 0x014 returns the four oldest receive bytes with the oldest in bits 31:24, then pops them. A byte read returns the oldest byte in bits 7:0 and pops it. engRxPush appends engRxByte.
- R6: Event bits 29:24 show the receive byte count and bits 21:16 show the transmit byte count. Both follow the FIFOs every cycle.
- R7: Event bit 9 is high while the receive FIFO holds data. Event bit 8 is high while the transmit FIFO has fewer than 32 bytes. Writing ones to these two bits changes nothing.
- R8: Both FIFOs hold 32 bytes, and every failed access leaves the FIFOs unchanged.
  - A transmit push that does not fit completely is dropped and sets bit 12.
  - A receive read asking for more bytes than are held returns zero, pops nothing, and sets bit 13.
  - An engine push into a full receive FIFO is dropped and sets bit 14.
  - An engine pop from an empty transmit FIFO sets bit 15.
- R9: Bits 15:12 are sticky. Writing a 1 to one of them at 0x004 clears it, and writing a 0 leaves it alone. If the flag is set again in the same cycle as the clear, the set wins.
- R10: The mask register at 0x008 keeps only bits 15:12, 9 and 8, and its other bits read zero. The interrupt is high exactly when some event flag among those bits is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busByte | input | 1 | 1 = byte-wide access to a data port |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| engTxPop | input | 1 | Engine takes one transmit byte |
| engTxByte | output | 8 | Oldest transmit byte |
| engRxPush | input | 1 | Engine delivers one received byte |
| engRxByte | input | 8 | Received byte |
| cfgEnable | output | 1 | Unit enable |
| cfgLoop | output | 1 | Internal loopback select |
| cfgTxThr | output | 6 | Transmit threshold |
| cfgRxThr | output | 6 | Receive threshold |
| cfgCommand | output | 32 | Stored command word |
| cfgCsMode | output | 128 | Chip-select mode words, word n at bits 32n+31:32n |
| irq | output | 1 | Interrupt request |

## Verification
The transmit FIFO is exercised in several ways:
- It is filled by eight word writes to exactly full, then drained by engine pops. This separates lane ordering errors from count errors.
- It is filled with thirty single bytes and then offered a word that overshoots by two. This shows that a push is all-or-nothing, not partial.

The receive FIFO is exercised in a similar way:
- It is overfilled by one byte, then drained by word reads.
- A word read is tried against three held bytes, and those bytes are then collected by byte reads. This tells the word-pop path from the byte-pop path.

Sticky flags are cleared one at a time and all together. A clear is also issued in the same cycle as a new set, and ones are written to the live level flags. The interrupt is swept through one mask bit at a time, covering live flags and sticky flags alike.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_AW = 8;
  localparam int THR_W  = 6;
  localparam int LANES  = 4;

  localparam logic [REG_AW-1:0] OFS_MODE   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_EVENT  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CMD    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_TXDATA = 8'h10;
  localparam logic [REG_AW-1:0] OFS_RXDATA = 8'h14;
  localparam logic [REG_AW-1:0] OFS_CS     = 8'h20;

  localparam int EV_TXNF  = 8;
  localparam int EV_RXNE  = 9;
  localparam int EV_STICK = 12;  // sticky flags occupy bits 15:12
  localparam logic [15:0] FLAG_BITS = 16'hF300;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_EVENT, RD_MASK, RD_CMD, RD_RXDATA, RD_CSMODE
  } rdSel_t;

  // setFlag: [0] tx push overflow, [1] rx read underflow,
  //          [2] rx engine overflow, [3] tx engine underflow
  typedef struct packed {
    logic       wrMode;
    logic       wrEvent;
    logic       wrMask;
    logic       wrCmd;
    logic       wrCs;
    logic [3:0] csIdx;
    rdSel_t     rdSel;
    logic [2:0] txPushN;
    logic [2:0] rxPopN;
    logic       txEngPop;
    logic       rxEngPush;
    logic [3:0] setFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         pushN,
  input  logic [8*LANES-1:0] pushWord,
  input  logic [2:0]         popN,
  output logic [8*LANES-1:0] headWord,
  output logic [CNT_W-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(pushN)) mem[wrPtr + PTR_W'(i)] <= pushWord[8*(LANES-1-i) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      count <= count + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gHead
    assign headWord[8*(LANES-1-g) +: 8] = mem[rdPtr + PTR_W'(g)];
  end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busByte,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  output ctrlStrobe_t       strobe
);
  logic              wrAcc;
  logic              rdAcc;
  logic [2:0]        nBytes;
  logic [REG_AW-1:0] csOfs;
  logic              csHit;

  always_comb begin
    strobe = '0;
    wrAcc  = busSel & busWrite;
    rdAcc  = busSel & ~busWrite;
    nBytes = busByte ? 3'd1 : 3'd4;
    csOfs  = busAddr - OFS_CS;
    csHit  = (busAddr >= OFS_CS) && (int'(csOfs) < 4 * NUM_CS) && (busAddr[1:0] == 2'b00);
    strobe.csIdx = 4'(csOfs >> 2);

    if (wrAcc) begin
      case (busAddr)
        OFS_MODE:  strobe.wrMode  = 1'b1;
        OFS_EVENT: strobe.wrEvent = 1'b1;
        OFS_MASK:  strobe.wrMask  = 1'b1;
        OFS_CMD:   strobe.wrCmd   = 1'b1;
        OFS_TXDATA: begin
          if (int'(txCount) + int'(nBytes) <= DEPTH) strobe.txPushN = nBytes;
          else strobe.setFlag[0] = 1'b1;
        end
        default: strobe.wrCs = csHit;
      endcase
    end

    if (rdAcc) begin
      case (busAddr)
        OFS_MODE:  strobe.rdSel = RD_MODE;
        OFS_EVENT: strobe.rdSel = RD_EVENT;
        OFS_MASK:  strobe.rdSel = RD_MASK;
        OFS_CMD:   strobe.rdSel = RD_CMD;
        OFS_RXDATA: begin
          strobe.rdSel = RD_RXDATA;
          if (int'(rxCount) >= int'(nBytes)) strobe.rxPopN = nBytes;
          else strobe.setFlag[1] = 1'b1;
        end
        default: strobe.rdSel = csHit ? RD_CSMODE : RD_NONE;
      endcase
    end

    // engine side: checked against the counts held at the start of the cycle
    strobe.rxEngPush  = engRxPush && (int'(rxCount) < DEPTH);
    strobe.setFlag[2] = engRxPush && (int'(rxCount) >= DEPTH);
    strobe.txEngPop   = engTxPop && (txCount != '0);
    strobe.setFlag[3] = engTxPop && (txCount == '0);
  end
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [31:0]           busWdata,
  input  logic [7:0]            engRxByte,
  output logic [31:0]           busRdata,
  output logic [7:0]            engTxByte,
  output logic                  cfgEnable,
  output logic                  cfgLoop,
  output logic [THR_W-1:0]      cfgTxThr,
  output logic [THR_W-1:0]      cfgRxThr,
  output logic [31:0]           cfgCommand,
  output logic [NUM_CS*32-1:0]  cfgCsMode,
  output logic                  irq,
  output logic [CNT_W-1:0]      txCount,
  output logic [CNT_W-1:0]      rxCount,
  output logic [15:0]           maskReg,
  output logic [3:0]            sticky
);
  logic [31:0] txPushWord;
  logic [31:0] txHead;
  logic [31:0] rxHead;
  logic [31:0] eventWord;

  assign txPushWord = (strobe.txPushN == 3'd1) ? {busWdata[7:0], 24'h0} : busWdata;

  spi_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LANES(LANES)) u_txFifo (
    .clk, .rstN,
    .pushN(strobe.txPushN), .pushWord(txPushWord),
    .popN({2'b00, strobe.txEngPop}),
    .headWord(txHead), .count(txCount)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LANES(LANES)) u_rxFifo (
    .clk, .rstN,
    .pushN({2'b00, strobe.rxEngPush}), .pushWord({engRxByte, 24'h0}),
    .popN(strobe.rxPopN),
    .headWord(rxHead), .count(rxCount)
  );

  assign engTxByte = txHead[31:24];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable  <= 1'b0;
      cfgLoop    <= 1'b0;
      cfgTxThr   <= '0;
      cfgRxThr   <= '0;
      cfgCommand <= '0;
      maskReg    <= '0;
      sticky     <= '0;
    end else begin
      if (strobe.wrMode) begin
        cfgEnable <= busWdata[31];
        cfgLoop   <= busWdata[30];
        cfgTxThr  <= busWdata[8 +: THR_W];
        cfgRxThr  <= busWdata[0 +: THR_W];
      end
      if (strobe.wrCmd)  cfgCommand <= busWdata;
      if (strobe.wrMask) maskReg    <= busWdata[15:0] & FLAG_BITS;
      sticky <= (sticky & ~(strobe.wrEvent ? busWdata[EV_STICK +: 4] : 4'h0)) | strobe.setFlag;
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : gCs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgCsMode[32*c +: 32] <= '0;
      else if (strobe.wrCs && (int'(strobe.csIdx) == c)) cfgCsMode[32*c +: 32] <= busWdata;
    end
  end

  always_comb begin
    eventWord = '0;
    eventWord[24 +: CNT_W]   = rxCount;
    eventWord[16 +: CNT_W]   = txCount;
    eventWord[EV_STICK +: 4] = sticky;
    eventWord[EV_RXNE]       = (rxCount != '0);
    eventWord[EV_TXNF]       = (int'(txCount) != DEPTH);
  end

  assign irq = |(eventWord[15:0] & maskReg);

  always_comb begin
    case (strobe.rdSel)
      RD_MODE:   busRdata = {cfgEnable, cfgLoop, 16'h0, cfgTxThr, 2'b00, cfgRxThr};
      RD_EVENT:  busRdata = eventWord;
      RD_MASK:   busRdata = {16'h0, maskReg};
      RD_CMD:    busRdata = cfgCommand;
      RD_RXDATA: begin
        if (strobe.rxPopN == 3'd4)      busRdata = rxHead;
        else if (strobe.rxPopN == 3'd1) busRdata = {24'h0, rxHead[31:24]};
        else                            busRdata = '0;
      end
      RD_CSMODE: busRdata = cfgCsMode[32*int'(strobe.csIdx) +: 32];
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NUM_CS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic                 busByte,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 engTxPop,
  output logic [7:0]           engTxByte,
  input  logic                 engRxPush,
  input  logic [7:0]           engRxByte,
  output logic                 cfgEnable,
  output logic                 cfgLoop,
  output logic [5:0]           cfgTxThr,
  output logic [5:0]           cfgRxThr,
  output logic [31:0]          cfgCommand,
  output logic [NUM_CS*32-1:0] cfgCsMode,
  output logic                 irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;
  logic [15:0]      maskReg;
  logic [3:0]       sticky;

  spi_fifo_ctrl #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_ctrl (
    .busSel, .busWrite, .busByte, .busAddr,
    .engTxPop, .engRxPush, .txCount, .rxCount, .strobe
  );

  spi_fifo_dp #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .strobe, .busWdata, .engRxByte, .busRdata, .engTxByte,
    .cfgEnable, .cfgLoop, .cfgTxThr, .cfgRxThr, .cfgCommand, .cfgCsMode,
    .irq, .txCount, .rxCount, .maskReg, .sticky
  );
endmodule

// File: rtl/spi_fifo_status_chk.sv
module spi_fifo_status_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic [7:0]       busAddr,
  input logic [31:0]      busRdata,
  input logic             engTxPop,
  input logic             engRxPush,
  input logic             irq,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [15:0]      maskReg,
  input logic [3:0]       sticky
);
  logic evWrite;
  assign evWrite = busSel && busWrite && (busAddr == 8'h04);

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txCount) <= DEPTH) && (int'(rxCount) <= DEPTH));

  // R4: an engine pop with no bus access removes exactly one byte
  a_r4_eng_pop: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && engTxPop && txCount != '0) |=> txCount == CNT_W'($past(txCount) - 1'b1));

  // R5: an engine push with room and no bus access adds exactly one byte
  a_r5_eng_push: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && engRxPush && int'(rxCount) < DEPTH) |=> rxCount == CNT_W'($past(rxCount) + 1'b1));

  // R8: engine pop of an empty transmit FIFO raises the underflow flag
  a_r8_tx_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && txCount == '0) |=> sticky[3]);

  // R8: engine push into a full receive FIFO raises the overflow flag
  a_r8_rx_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && int'(rxCount) == DEPTH) |=> sticky[2]);

  // R7: the not-full flag seen on the bus follows the transmit count
  a_r7_tx_not_full: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == 8'h04) |-> busRdata[8] == (int'(txCount) != DEPTH));

  // R9: sticky flags only drop on a write to the event register
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !evWrite |=> (sticky & $past(sticky)) == $past(sticky));

  // R10: a cleared mask keeps the interrupt low
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == 16'h0) |-> !irq);
endmodule

bind spi_fifo_status spi_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .engTxPop(engTxPop),
  .engRxPush(engRxPush), .irq(irq), .txCount(txCount), .rxCount(rxCount),
  .maskReg(maskReg), .sticky(sticky)
);

// File: tb/spi_fifo_status_bench.sv
`timescale 1ns/1ps
module spi_fifo_status_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0, busWrite = 1'b0, busByte = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         engTxPop = 1'b0, engRxPush = 1'b0;
  logic [7:0]   engRxByte = '0;
  logic [7:0]   engTxByte;
  logic         cfgEnable, cfgLoop, irq;
  logic [5:0]   cfgTxThr, cfgRxThr;
  logic [31:0]  cfgCommand;
  logic [127:0] cfgCsMode;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_fifo_status u_spi_fifo_status (
    .clk, .rstN, .busSel, .busWrite, .busByte, .busAddr, .busWdata, .busRdata,
    .engTxPop, .engTxByte, .engRxPush, .engRxByte, .cfgEnable, .cfgLoop,
    .cfgTxThr, .cfgRxThr, .cfgCommand, .cfgCsMode, .irq
  );

  function automatic logic [7:0] txv(int n); return 8'(n * 7 + 3); endfunction
  function automatic logic [7:0] rxv(int n); return 8'(n * 5 + 1); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, w, b, input logic [7:0] a, input logic [31:0] d,
                     input logic tp, rp, input logic [7:0] rb,
                     output logic [31:0] rdv, output logic [7:0] txb);
    @(negedge clk);
    busSel = s; busWrite = w; busByte = b; busAddr = a; busWdata = d;
    engTxPop = tp; engRxPush = rp; engRxByte = rb;
    #1;
    rdv = busRdata;
    txb = engTxByte;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0; busByte = 1'b0; engTxPop = 1'b0; engRxPush = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; logic [7:0] t;
    cyc(1, 1, 0, a, d, 0, 0, 0, r, t);
  endtask
  task automatic wrB(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; logic [7:0] t;
    cyc(1, 1, 1, a, d, 0, 0, 0, r, t);
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    logic [7:0] t;
    cyc(1, 0, 0, a, 0, 0, 0, 0, v, t);
  endtask
  task automatic rdB(input logic [7:0] a, output logic [31:0] v);
    logic [7:0] t;
    cyc(1, 0, 1, a, 0, 0, 0, 0, v, t);
  endtask
  task automatic pop(output logic [7:0] b);
    logic [31:0] r;
    cyc(0, 0, 0, 0, 0, 1, 0, 0, r, b);
  endtask
  task automatic push(input logic [7:0] b);
    logic [31:0] r; logic [7:0] t;
    cyc(0, 0, 0, 0, 0, 0, 1, b, r, t);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(8'h00, v); check("R1 mode", v, 32'h0);
    rd(8'h04, v); check("R1 event", v, 32'h0000_0100);
    rd(8'h08, v); check("R1 mask", v, 32'h0);
    rd(8'h0C, v); check("R1 command", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(8'(32 + 4 * i), v); check("R1 csmode", v, 32'h0);
    end
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2: mode fields
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 mode all ones", v, 32'hC000_3F3F);
    check("R2 outputs", {cfgEnable, cfgLoop, cfgTxThr, cfgRxThr}, {2'b11, 6'h3F, 6'h3F});
    wr(8'h00, 32'h4000_0A05);
    rd(8'h00, v); check("R2 mode pattern", v, 32'h4000_0A05);
    check("R2 outputs pattern", {cfgEnable, cfgLoop, cfgTxThr, cfgRxThr}, {2'b01, 6'h0A, 6'h05});

    // R3: command and chip-select words
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, v); check("R3 command", v, 32'hDEAD_BEEF);
    check("R3 cfgCommand", cfgCommand, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) wr(8'(32 + 4 * i), (32'h0102_0304 * (i + 1)) ^ 32'hA500_0000);
    for (int i = 0; i < 4; i++) begin
      rd(8'(32 + 4 * i), v); check("R3 csmode read", v, (32'h0102_0304 * (i + 1)) ^ 32'hA500_0000);
      check("R3 cfgCsMode", cfgCsMode[32*i +: 32], (32'h0102_0304 * (i + 1)) ^ 32'hA500_0000);
    end

    // R4/R6/R7: fill transmit FIFO with words
    for (int k = 0; k < 8; k++) begin
      wr(8'h10, {txv(4*k), txv(4*k+1), txv(4*k+2), txv(4*k+3)});
      rd(8'h04, v);
      check("R6 tx count", {26'h0, v[21:16]}, 32'(4 * (k + 1)));
      check("R7 tx not full", {31'h0, v[8]}, (k < 7) ? 32'h1 : 32'h0);
    end
    wr(8'h10, 32'h1234_5678);
    rd(8'h04, v); check("R8 tx word overflow", v, 32'h0020_1000);
    for (int n = 0; n < 32; n++) begin
      pop(b); check("R4 tx byte order", {24'h0, b}, {24'h0, txv(n)});
    end
    rd(8'h04, v); check("R6 tx drained", v, 32'h0000_1100);
    pop(b);
    rd(8'h04, v); check("R8 tx underflow", v, 32'h0000_9100);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R9 clear all", v, 32'h0000_0100);

    // R4: byte write
    wrB(8'h10, 32'h0000_00A5);
    rd(8'h04, v); check("R6 tx one byte", v, 32'h0001_0100);
    pop(b); check("R4 byte write data", {24'h0, b}, 32'hA5);

    // R8: word that only partly fits is dropped whole
    for (int n = 0; n < 30; n++) wrB(8'h10, {24'h0, txv(n + 100)});
    wr(8'h10, 32'hCAFE_F00D);
    rd(8'h04, v); check("R8 tx partial fit", v, 32'h001E_1100);
    for (int n = 0; n < 30; n++) begin
      pop(b); check("R8 tx contents kept", {24'h0, b}, {24'h0, txv(n + 100)});
    end
    wr(8'h04, 32'h0000_1000);
    rd(8'h04, v); check("R9 clear one flag", v, 32'h0000_0100);

    // R5/R8: receive side
    for (int n = 0; n < 32; n++) push(rxv(n));
    push(8'hEE);
    rd(8'h04, v); check("R8 rx overflow", v, 32'h2000_4300);
    for (int k = 0; k < 8; k++) begin
      rd(8'h14, v); check("R5 rx word", v, {rxv(4*k), rxv(4*k+1), rxv(4*k+2), rxv(4*k+3)});
      rd(8'h04, v); check("R6 rx count", {26'h0, v[29:24]}, 32'(32 - 4 * (k + 1)));
    end
    for (int n = 40; n < 43; n++) push(rxv(n));
    rd(8'h14, v); check("R8 rx short word read", v, 32'h0);
    rd(8'h04, v); check("R8 rx underflow", v, 32'h0300_6300);
    for (int n = 40; n < 43; n++) begin
      rdB(8'h14, v); check("R5 rx byte read", v, {24'h0, rxv(n)});
    end
    rd(8'h04, v); check("R6 rx drained", v, 32'h0000_6100);

    // R9/R7: selective clear, live flags unaffected
    wr(8'h04, 32'h0000_2000);
    rd(8'h04, v); check("R9 partial clear", v, 32'h0000_4100);
    push(rxv(50));
    wr(8'h04, 32'h0000_0300);
    rd(8'h04, v); check("R7 live flags ignore write", v, 32'h0100_4300);
    rdB(8'h14, v); check("R5 rx byte after", v, {24'h0, rxv(50)});
    wr(8'h04, 32'hFFFF_FFFF);
    cyc(1, 1, 0, 8'h04, 32'h0000_8000, 1, 0, 0, v, b);
    rd(8'h04, v); check("R9 set wins over clear", v, 32'h0000_8100);
    wr(8'h04, 32'hFFFF_FFFF);

    // R10: mask and interrupt
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R10 mask readback", v, 32'h0000_F300);
    check("R10 irq tx not full", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h0000_0200);
    check("R10 irq rx empty", {31'h0, irq}, 32'h0);
    push(8'h77);
    check("R10 irq rx data", {31'h0, irq}, 32'h1);
    rdB(8'h14, v);
    check("R10 irq rx drained", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h0000_8000);
    pop(b);
    check("R10 irq sticky", {31'h0, irq}, 32'h1);
    wr(8'h04, 32'h0000_8000);
    check("R10 irq cleared", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h0);
    pop(b);
    rd(8'h04, v); check("R10 flag without mask", v, 32'h0000_8100);
    check("R10 irq masked off", {31'h0, irq}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule